// File: doc/BRIEF.md
# Descrambled Test Pattern Verifier

This block watches the 66-bit blocks that leave a receive descrambler (a 2-bit sync header plus a 64-bit payload) and confirms that a link in test mode is carrying the expected fixed test pattern. It only looks at blocks while the block synchronizer reports lock. Each valid block is compared against the selected pattern and against that pattern's exact bitwise inverse, across all 66 bits. Mismatching blocks are tallied in a saturating counter.

Two fixed patterns are available. One is a data block of all zeros. The other is a control block that carries a local-fault ordered set in both of its lanes. The first block that matches either form fixes the expected polarity. After that, only that form is accepted. The block's error pulse is ORed with an error input from a neighbouring pseudo-random sequence checker, so both sources share one error flag.

Top module: `test_pattern_verifier`

## Requirements
- R1: While reset is active (`rst_n` low), and on the first cycle after it, `err_cnt` is 0 and the registered error pulse is low.
- R2: A block is not evaluated when `blk_lock` is low or `rx_valid` is low. Such a block never raises `err_flag` and never changes `err_cnt`.
- R3: With `pat_sel`=0, the normal pattern is header 2'b01 with a payload of all zeros, and the inverse is header 2'b10 with a payload of all ones. Any other 66-bit value, including a wrong header alone, is a mismatch.
- R4: With `pat_sel`=1, the normal pattern is header 2'b10 with payload 64'h0100_0000_0100_0055. Bits [7:0] hold block type 0x55, both 4-bit sequence codes are 0, and the top byte of each 24-bit lane field is 0x01. The inverse is header 2'b01 with the bitwise complement of that payload.
- R5: The first evaluated block that equals the normal or the inverse form fixes the polarity and is not an error. Each later evaluated block that differs from the fixed form, including one of the opposite polarity, is an error.
- R6: While no polarity is fixed, an evaluated block that equals neither form is an error, and the polarity stays unfixed.
- R7: Each error adds one to `err_cnt`. The count holds at 16'hFFFF instead of wrapping.
- R8: `cnt_clr` zeroes `err_cnt` and unfixes the polarity. It takes priority over a block presented in the same cycle, and that block is not evaluated.
- R9: A cycle with `blk_lock` low unfixes the polarity but keeps `err_cnt`.
- R10: `err_flag` is high for exactly one cycle, the cycle after each erroneous block (also while saturated). It is also high in any cycle in which `prbs_err_in` is high, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_lock | input | 1 | Block synchronizer reports lock |
| rx_valid | input | 1 | A block is present this cycle |
| rx_hdr | input | 2 | Sync header of the block |
| rx_data | input | 64 | Descrambled block payload |
| pat_sel | input | 1 | 0: all-zeros pattern, 1: local-fault pattern |
| cnt_clr | input | 1 | Clear count and polarity |
| prbs_err_in | input | 1 | Error from the sequence checker, ORed onto the flag |
| err_cnt | output | 16 | Saturating mismatch count |
| err_flag | output | 1 | Combined error indication |

## Verification
The bench targets several specific failure modes.
- **Polarity fixing.** A design that accepts both forms forever would miss an opposite-polarity block after the polarity is fixed. A design that counts the very first inverse block would inflate the count.
- **Lock loss.** A design that keeps the polarity through lock loss would flag a relock onto the inverse. A design that resets the count on lock loss would lose the tally.
- **Clear priority.** The bench presents a clear together with a garbage block. If the block is evaluated anyway, a count or flag appears.
- **Saturation.** The bench drives more than 65535 errors. A wrapping counter reads a small value, and a design that stops pulsing at the limit leaves the flag low.
- **Encodings.** Header-only mismatches and a single flipped local-fault bit catch encoding mistakes.

// File: rtl/tpv_pkg.sv
package tpv_pkg;

    localparam int HDR_W = 2;
    localparam int PAY_W = 64;
    localparam int BLK_W = HDR_W + PAY_W;

    localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

    // local-fault control block: type byte, two zero sequence codes, 0x01 at the top of each lane
    localparam logic [7:0] BT_SEQ    = 8'h55;
    localparam logic [7:0] FAULT_LOC = 8'h01;

    typedef enum logic {
        PAT_ZEROS = 1'b0,
        PAT_LFAULT = 1'b1
    } pat_kind_e;

    typedef struct packed {
        logic pol_set;   // a polarity has been fixed
        logic pol_inv;   // fixed polarity is the inverse form
        logic err;       // one-cycle error pulse
    } tpv_state_t;

endpackage

// File: rtl/tpv_pattern_gen.sv
module tpv_pattern_gen
    import tpv_pkg::*;
(
    input  pat_kind_e        kind,
    output logic [BLK_W-1:0] pattern
);
    localparam int LANES  = 2;
    localparam int LANE_W = PAY_W / LANES;

    logic [PAY_W-1:0] lf_payload;

    // each 32-bit lane: [3:0] type-or-code, fault byte at its top
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        if (ln == 0) begin : g_first
            assign lf_payload[ln*LANE_W +: LANE_W] = {FAULT_LOC, 16'h0000, BT_SEQ};
        end else begin : g_other
            assign lf_payload[ln*LANE_W +: LANE_W] = {FAULT_LOC, 16'h0000, 4'h0, 4'h0};
        end
    end

    always_comb begin
        unique case (kind)
            PAT_LFAULT: pattern = {HDR_CTRL, lf_payload};
            default:    pattern = {HDR_DATA, {PAY_W{1'b0}}};
        endcase
    end
endmodule

// File: rtl/tpv_match.sv
module tpv_match
    import tpv_pkg::*;
(
    input  logic [BLK_W-1:0] blk,
    input  logic [BLK_W-1:0] pattern,
    output logic             is_norm,
    output logic             is_inv
);
    logic [BLK_W-1:0] diff;

    always_comb begin
        diff    = blk ^ pattern;
        is_norm = (diff == '0);
        is_inv  = (diff == '1);
    end
endmodule

// File: rtl/tpv_sat_cnt.sv
module tpv_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q != TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/test_pattern_verifier.sv
module test_pattern_verifier
    import tpv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_lock,
    input  logic             rx_valid,
    input  logic [1:0]       rx_hdr,
    input  logic [63:0]      rx_data,
    input  logic             pat_sel,
    input  logic             cnt_clr,
    input  logic             prbs_err_in,
    output logic [CNT_W-1:0] err_cnt,
    output logic             err_flag
);
    tpv_state_t       st_d, st_q;
    logic [BLK_W-1:0] pattern;
    logic             is_norm, is_inv;
    pat_kind_e        kind;

    assign kind = pat_kind_e'(pat_sel);

    tpv_pattern_gen u_pat (
        .kind    (kind),
        .pattern (pattern)
    );

    tpv_match u_match (
        .blk     ({rx_hdr, rx_data}),
        .pattern (pattern),
        .is_norm (is_norm),
        .is_inv  (is_inv)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (cnt_clr || !blk_lock) begin
            st_d.pol_set = 1'b0;
        end else if (rx_valid) begin
            if (!st_q.pol_set) begin
                if (is_norm || is_inv) begin
                    st_d.pol_set = 1'b1;
                    st_d.pol_inv = is_inv;
                end else begin
                    st_d.err = 1'b1;
                end
            end else begin
                st_d.err = st_q.pol_inv ? !is_inv : !is_norm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tpv_sat_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (st_d.err),
        .cnt   (err_cnt)
    );

    assign err_flag = st_q.err | prbs_err_in;
endmodule

// File: rtl/tpv_checker.sv
module tpv_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             blk_lock,
    input logic             rx_valid,
    input logic             cnt_clr,
    input logic             prbs_err_in,
    input logic [CNT_W-1:0] err_cnt,
    input logic             err_flag
);
    localparam logic [CNT_W-1:0] TOP = '1;

    a_r2_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && (!blk_lock || !rx_valid)) |=> (err_cnt == $past(err_cnt)));

    a_r7_step_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_clr) |-> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == TOP && !cnt_clr) |=> (err_cnt == TOP));

    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (err_cnt == '0 && !err_flag || prbs_err_in && err_cnt == '0));

    a_r10_count_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_clr) && err_cnt != $past(err_cnt)) |-> err_flag);

    a_r10_prbs_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        prbs_err_in |-> err_flag);
endmodule

bind test_pattern_verifier tpv_checker #(.CNT_W(CNT_W)) u_tpv_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_lock    (blk_lock),
    .rx_valid    (rx_valid),
    .cnt_clr     (cnt_clr),
    .prbs_err_in (prbs_err_in),
    .err_cnt     (err_cnt),
    .err_flag    (err_flag)
);

// File: tb/test_pattern_verifier_bench.sv
module test_pattern_verifier_bench;
    localparam logic [63:0] PZ  = 64'h0;
    localparam logic [63:0] PO  = ~64'h0;
    localparam logic [63:0] LF  = 64'h0100_0000_0100_0055;
    localparam logic [63:0] LFI = ~LF;
    localparam logic [63:0] LFB = 64'h0000_0000_0100_0055; // lane 1 fault byte cleared

    typedef struct packed {
        logic        lock;
        logic        valid;
        logic [1:0]  hdr;
        logic [63:0] data;
        logic        sel;
        logic        clr;
        logic        exp_flag;
        logic [15:0] exp_cnt;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{1,1,2'b01,PZ,        0,0,0,16'd0},  // R3 normal zeros fixes polarity
        '{1,1,2'b01,PZ,        0,0,0,16'd0},  // R5
        '{1,1,2'b10,PO,        0,0,1,16'd1},  // R5 opposite polarity
        '{1,1,2'b01,64'h1,     0,0,1,16'd2},  // R3 single bit
        '{0,1,2'b11,64'hDEAD,  0,0,0,16'd2},  // R2 no lock, R9
        '{1,0,2'b11,64'hBEEF,  0,0,0,16'd2},  // R2 not valid
        '{1,1,2'b10,PO,        0,0,0,16'd2},  // R9 relock on inverse
        '{1,1,2'b10,PO,        0,0,0,16'd2},  // R9
        '{1,1,2'b11,64'h1234,  0,1,0,16'd0},  // R8 clear wins
        '{1,1,2'b01,PZ,        0,0,0,16'd0},  // R8 polarity refixed
        '{1,1,2'b10,LF,        1,0,0,16'd0},  // R4 normal LF
        '{1,1,2'b01,LFI,       1,0,1,16'd1},  // R4 inverse after normal fixed
        '{1,1,2'b10,PZ,        1,0,1,16'd2},  // R4 wrong payload
        '{0,0,2'b00,PZ,        1,0,0,16'd2},  // R9 lock loss
        '{1,1,2'b10,LFB,       1,0,1,16'd3},  // R6 neither form
        '{1,1,2'b01,LFI,       1,0,0,16'd3},  // R4 inverse fixes polarity
        '{1,1,2'b01,LFI,       1,0,0,16'd3},  // R5
        '{1,1,2'b00,PZ,        0,0,1,16'd4}   // R3 header-only mismatch
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_lock = 1'b0;
    logic        rx_valid = 1'b0;
    logic [1:0]  rx_hdr = 2'b00;
    logic [63:0] rx_data = '0;
    logic        pat_sel = 1'b0;
    logic        cnt_clr = 1'b0;
    logic        prbs_err_in = 1'b0;
    logic [15:0] err_cnt;
    logic        err_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    test_pattern_verifier u_test_pattern_verifier (
        .clk(clk), .rst_n(rst_n), .blk_lock(blk_lock), .rx_valid(rx_valid),
        .rx_hdr(rx_hdr), .rx_data(rx_data), .pat_sel(pat_sel), .cnt_clr(cnt_clr),
        .prbs_err_in(prbs_err_in), .err_cnt(err_cnt), .err_flag(err_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic l, input logic v, input logic [1:0] h,
                         input logic [63:0] d, input logic s, input logic c);
        blk_lock = l; rx_valid = v; rx_hdr = h; rx_data = d; pat_sel = s; cnt_clr = c;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cnt in reset", int'(err_cnt), 0);
        check("R1 flag in reset", int'(err_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cnt after reset", int'(err_cnt), 0);
        check("R1 flag after reset", int'(err_flag), 0);

        for (int i = 0; i < NV; i++) begin
            drive(VT[i].lock, VT[i].valid, VT[i].hdr, VT[i].data, VT[i].sel, VT[i].clr);
            @(negedge clk);
            check($sformatf("vec%0d flag", i), int'(err_flag), int'(VT[i].exp_flag));
            check($sformatf("vec%0d cnt", i), int'(err_cnt), int'(VT[i].exp_cnt));
        end

        // R10: pulse lasts one cycle
        drive(1, 0, 2'b00, PZ, 0, 0);
        @(negedge clk);
        check("R10 flag drops", int'(err_flag), 0);
        // R10: sequence-checker error passes straight to flag
        prbs_err_in = 1'b1;
        #1;
        check("R10 prbs passthrough", int'(err_flag), 1);
        @(negedge clk);
        check("R10 prbs no count", int'(err_cnt), 4);
        prbs_err_in = 1'b0;
        #1;
        check("R10 prbs release", int'(err_flag), 0);

        // R7: saturation
        drive(1, 1, 2'b00, PZ, 0, 1);
        @(negedge clk);
        cnt_clr = 1'b0;
        for (int k = 0; k < 65540; k++) @(negedge clk);
        check("R7 saturated", int'(err_cnt), 16'hFFFF);
        check("R10 flag while saturated", int'(err_flag), 1);
        @(negedge clk);
        check("R7 holds", int'(err_cnt), 16'hFFFF);
        drive(1, 0, 2'b00, PZ, 0, 1);
        @(negedge clk);
        check("R8 clear from max", int'(err_cnt), 0);
        drive(0, 0, 2'b00, PZ, 0, 0);

        // R1: reset mid-run
        drive(1, 1, 2'b11, PZ, 0, 0);
        @(negedge clk);
        check("R6 error before reset", int'(err_cnt), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears cnt", int'(err_cnt), 0);
        check("R1 reset clears flag", int'(err_flag), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule